// File: doc/BRIEF.md
# USB Endpoint Handshake Response Controller

This block sits between a USB device's packet decoder and its packet buffers. Every token the decoder sees arrives as a one-cycle event carrying the transaction kind (OUT, IN or SETUP) and an endpoint number. The block then decides how the device answers. For OUT and SETUP, the answer comes after the data packet. For IN, the answer is given straight away, and the block then waits for the host's handshake. Along the way it keeps the state of each of its endpoints: whether an IN buffer is armed, stall, data toggles, and sent and cancelled-IN flags.

Software arms an IN buffer by naming an endpoint, a buffer index and a byte count. It enables SETUP and OUT reception per endpoint, marks endpoints as isochronous, sets and clears stall, and clears the sent, cancelled and toggle state with write-one strobes. SETUP packets get special handling. They are accepted even on a stalled endpoint, and accepting one removes the stall. Accepting one also withdraws any armed IN buffer, which is flagged so software can re-arm it once the control sequence is over.

Top module: `usb_ep_handshake`

## Requirements
- R1: After reset no response is issued and every per-endpoint flag (armed, stall, sent, cancelled, both toggles) is 0.
- R2: An IN token to a valid endpoint produces `rspValid` in the next cycle. The answer is STALL (`rspKind`=3) if the endpoint is stalled, otherwise NACK (2) if no buffer is armed, otherwise DATA (4). DATA carries the armed buffer index and the endpoint's IN toggle.
- R3: For a DATA answer, `txBytes` equals the armed size when that is 64 or less (0 gives a CRC-only packet). A larger size is limited to 64.
- R4: An ACK handshake (`hsValid` with `hsAck`=1) after DATA on a non-isochronous endpoint clears that endpoint's armed bit, sets its sent flag and inverts its IN toggle. A `sentClr` bit clears the sent flag.
- R5: While a handshake is awaited, a non-ACK handshake or any new token pulses `inErr` and leaves the buffer armed.
- R6: An OUT data packet with good CRC is answered with STALL if the endpoint is stalled, otherwise NACK if OUT reception is disabled. Otherwise it gets ACK, and if its toggle bit (`dataPid`, 0=DATA0) matches the OUT toggle, `pktRx` pulses and the OUT toggle inverts.
- R7: An accepted OUT whose toggle bit does not match is still ACKed, but it pulses `outErr` instead of `pktRx` and leaves the OUT toggle unchanged.
- R8: A data packet with bad CRC after OUT or SETUP gets no response and pulses `outErr`.
- R9: A good SETUP data packet is answered with NACK when SETUP reception is disabled for the endpoint. When it is enabled, the packet is ACKed even on a stalled endpoint: `pktRx` pulses, the stall clears, and both toggles become 1.
- R10: An accepted SETUP on an endpoint with an armed IN buffer clears the armed bit and sets the cancelled flag. A `pendClr` bit clears the cancelled flag.
- R11: A link reset clears every armed bit, sets the cancelled flag of each endpoint that was armed, and abandons any awaited handshake.
- R12: On an isochronous endpoint a good OUT packet pulses `pktRx` with no response, and an IN DATA answer completes at once: armed clears and sent sets, with no handshake awaited.
- R13: A `togClr` bit sets both toggles of that endpoint to 0 (DATA0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tokValid | input | 1 | Token event strobe |
| tokKind | input | 2 | 0 OUT, 1 IN, 2 SETUP |
| tokEp | input | 4 | Token endpoint number |
| dataValid | input | 1 | Data packet received strobe |
| dataGood | input | 1 | Data packet CRC and format good |
| dataPid | input | 1 | Received toggle: 0 DATA0, 1 DATA1 |
| hsValid | input | 1 | Handshake received after IN data |
| hsAck | input | 1 | Handshake was a valid ACK |
| linkReset | input | 1 | Link reset strobe |
| setupEn | input | 12 | SETUP reception enable per endpoint |
| outEn | input | 12 | OUT reception enable per endpoint |
| isoEn | input | 12 | Isochronous mode per endpoint |
| stallSet | input | 12 | Set stall (write-one) |
| stallClr | input | 12 | Clear stall (write-one) |
| inSetValid | input | 1 | Arm an IN buffer |
| inSetEp | input | 4 | Endpoint to arm |
| inSetBuf | input | 5 | Buffer index to send |
| inSetSize | input | 7 | Byte count to send |
| sentClr | input | 12 | Clear sent flag (write-one) |
| pendClr | input | 12 | Clear cancelled flag (write-one) |
| togClr | input | 12 | Reset toggles to DATA0 (write-one) |
| rspValid | output | 1 | A response is to be transmitted |
| rspKind | output | 3 | 0 none, 1 ACK, 2 NACK, 3 STALL, 4 DATA |
| txBytes | output | 7 | Byte count for DATA |
| txBuf | output | 5 | Buffer index for DATA |
| txToggle | output | 1 | Toggle for DATA |
| inRdy | output | 12 | IN buffer armed per endpoint |
| stall | output | 12 | Stall per endpoint |
| sent | output | 12 | IN delivered per endpoint |
| pend | output | 12 | IN cancelled by hardware per endpoint |
| inTog | output | 12 | IN data toggle per endpoint |
| outTog | output | 12 | OUT data toggle per endpoint |
| inErr | output | 1 | IN transaction error pulse |
| outErr | output | 1 | OUT transaction error pulse |
| pktRx | output | 1 | Packet accepted pulse |

## Verification
Directed sequences first take each response branch one at a time. Stalled, disabled, unarmed and armed endpoints are each hit by IN, OUT and SETUP, which tells the priority order among stall, enable and armed apart. Matching and mismatched OUT toggles, good and bad CRC, and ACK versus non-ACK handshakes separate data acceptance from error reporting. A long pseudo-random phase then overlaps tokens, data, handshakes, link resets and software writes, including out-of-range endpoints. Its purpose is to expose ordering faults between hardware updates and software strobes that land on the same endpoint.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  parameter int EpIdW = 4;

  typedef enum logic [1:0] {
    TOK_OUT   = 2'd0,
    TOK_IN    = 2'd1,
    TOK_SETUP = 2'd2
  } tokKindE;

  typedef enum logic [2:0] {
    RSP_NONE  = 3'd0,
    RSP_ACK   = 3'd1,
    RSP_NACK  = 3'd2,
    RSP_STALL = 3'd3,
    RSP_DATA  = 3'd4
  } rspKindE;

  // strobes from the decision logic to the endpoint state bank
  typedef struct packed {
    logic [EpIdW-1:0] ep;
    logic             setupHit;
    logic             inDone;
    logic             inFlip;
    logic             outFlip;
  } epStrobeT;
endpackage

// File: rtl/usb_ep_ctrl.sv
module usb_ep_ctrl
  import usb_ep_pkg::*;
#(
  parameter int NumEps = 12,
  parameter int BufW   = 5,
  parameter int SizeW  = 7,
  parameter int MaxPkt = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tokValid,
  input  logic [1:0]              tokKind,
  input  logic [EpIdW-1:0]        tokEp,
  input  logic                    dataValid,
  input  logic                    dataGood,
  input  logic                    dataPid,
  input  logic                    hsValid,
  input  logic                    hsAck,
  input  logic                    linkReset,
  input  logic [NumEps-1:0]       setupEn,
  input  logic [NumEps-1:0]       outEn,
  input  logic [NumEps-1:0]       isoEn,
  input  logic [NumEps-1:0]       stall,
  input  logic [NumEps-1:0]       inRdy,
  input  logic [NumEps-1:0]       outTog,
  input  logic [NumEps-1:0]       inTog,
  input  logic [NumEps*BufW-1:0]  inBufFlat,
  input  logic [NumEps*SizeW-1:0] inSizeFlat,
  output epStrobeT                strb,
  output logic                    rspValid,
  output logic [2:0]              rspKind,
  output logic [SizeW-1:0]        txBytes,
  output logic [BufW-1:0]         txBuf,
  output logic                    txToggle,
  output logic                    inErr,
  output logic                    outErr,
  output logic                    pktRx
);
  localparam logic [EpIdW:0]   EpCount = (EpIdW+1)'(NumEps);
  localparam logic [SizeW-1:0] MaxLen  = SizeW'(MaxPkt);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_HS} stateE;

  stateE            st, stNext;
  logic [EpIdW-1:0] curEp, epNext;
  logic             curSetup, setupNext;
  logic             tokOk;
  logic [EpIdW-1:0] tEp;
  logic             rV, iE, oE, pk, load;
  rspKindE          rK;
  logic [SizeW-1:0] rawSize;

  assign tokOk   = ({1'b0, tokEp} < EpCount);
  assign tEp     = tokOk ? tokEp : '0;
  assign rawSize = inSizeFlat[tEp*SizeW +: SizeW];

  always_comb begin
    stNext    = st;
    epNext    = curEp;
    setupNext = curSetup;
    strb      = '0;
    rV        = 1'b0;
    rK        = RSP_NONE;
    iE        = 1'b0;
    oE        = 1'b0;
    pk        = 1'b0;
    load      = 1'b0;
    if (linkReset) begin
      stNext = S_IDLE;
    end else if (tokValid) begin
      if (st == S_HS) iE = 1'b1;
      stNext = S_IDLE;
      if (tokOk) begin
        case (tokKind)
          TOK_IN: begin
            rV = 1'b1;
            if (stall[tEp])       rK = RSP_STALL;
            else if (!inRdy[tEp]) rK = RSP_NACK;
            else begin
              rK   = RSP_DATA;
              load = 1'b1;
              if (isoEn[tEp]) begin
                strb.ep     = tEp;
                strb.inDone = 1'b1;
              end else begin
                stNext = S_HS;
                epNext = tEp;
              end
            end
          end
          TOK_OUT, TOK_SETUP: begin
            stNext    = S_DATA;
            epNext    = tEp;
            setupNext = (tokKind == TOK_SETUP);
          end
          default: ;
        endcase
      end
    end else if (dataValid && st == S_DATA) begin
      stNext  = S_IDLE;
      strb.ep = curEp;
      if (!dataGood) begin
        oE = 1'b1;
      end else if (curSetup) begin
        rV = 1'b1;
        if (!setupEn[curEp]) rK = RSP_NACK;
        else begin
          rK            = RSP_ACK;
          pk            = 1'b1;
          strb.setupHit = 1'b1;
        end
      end else if (stall[curEp]) begin
        rV = 1'b1;
        rK = RSP_STALL;
      end else if (!outEn[curEp]) begin
        rV = 1'b1;
        rK = RSP_NACK;
      end else if (isoEn[curEp]) begin
        pk = 1'b1;
      end else begin
        rV = 1'b1;
        rK = RSP_ACK;
        if (dataPid != outTog[curEp]) oE = 1'b1;
        else begin
          pk           = 1'b1;
          strb.outFlip = 1'b1;
        end
      end
    end else if (hsValid && st == S_HS) begin
      stNext = S_IDLE;
      if (hsAck) begin
        strb.ep     = curEp;
        strb.inDone = 1'b1;
        strb.inFlip = 1'b1;
      end else begin
        iE = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st       <= S_IDLE;
      curEp    <= '0;
      curSetup <= 1'b0;
      rspValid <= 1'b0;
      rspKind  <= RSP_NONE;
      txBytes  <= '0;
      txBuf    <= '0;
      txToggle <= 1'b0;
      inErr    <= 1'b0;
      outErr   <= 1'b0;
      pktRx    <= 1'b0;
    end else begin
      st       <= stNext;
      curEp    <= epNext;
      curSetup <= setupNext;
      rspValid <= rV;
      rspKind  <= rK;
      inErr    <= iE;
      outErr   <= oE;
      pktRx    <= pk;
      if (load) begin
        txBytes  <= (rawSize > MaxLen) ? MaxLen : rawSize;
        txBuf    <= inBufFlat[tEp*BufW +: BufW];
        txToggle <= inTog[tEp];
      end
    end
  end
endmodule

// File: rtl/usb_ep_state.sv
module usb_ep_state
  import usb_ep_pkg::*;
#(
  parameter int NumEps = 12,
  parameter int BufW   = 5,
  parameter int SizeW  = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  epStrobeT                strb,
  input  logic                    linkReset,
  input  logic                    inSetValid,
  input  logic [EpIdW-1:0]        inSetEp,
  input  logic [BufW-1:0]         inSetBuf,
  input  logic [SizeW-1:0]        inSetSize,
  input  logic [NumEps-1:0]       stallSet,
  input  logic [NumEps-1:0]       stallClr,
  input  logic [NumEps-1:0]       sentClr,
  input  logic [NumEps-1:0]       pendClr,
  input  logic [NumEps-1:0]       togClr,
  output logic [NumEps-1:0]       inRdy,
  output logic [NumEps-1:0]       stall,
  output logic [NumEps-1:0]       sent,
  output logic [NumEps-1:0]       pend,
  output logic [NumEps-1:0]       inTog,
  output logic [NumEps-1:0]       outTog,
  output logic [NumEps*BufW-1:0]  inBufFlat,
  output logic [NumEps*SizeW-1:0] inSizeFlat
);
  for (genvar i = 0; i < NumEps; i++) begin : gEp
    logic hit, setupC, doneC, armC;
    assign hit    = (strb.ep == EpIdW'(i));
    assign setupC = hit && strb.setupHit;
    assign doneC  = hit && strb.inDone;
    assign armC   = inSetValid && (inSetEp == EpIdW'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inRdy[i]                      <= 1'b0;
        stall[i]                      <= 1'b0;
        sent[i]                       <= 1'b0;
        pend[i]                       <= 1'b0;
        inTog[i]                      <= 1'b0;
        outTog[i]                     <= 1'b0;
        inBufFlat[i*BufW +: BufW]     <= '0;
        inSizeFlat[i*SizeW +: SizeW]  <= '0;
      end else begin
        if (armC) inRdy[i] <= 1'b1;
        else if (linkReset || setupC || doneC) inRdy[i] <= 1'b0;

        if (inRdy[i] && (linkReset || setupC)) pend[i] <= 1'b1;
        else if (pendClr[i]) pend[i] <= 1'b0;

        if (doneC) sent[i] <= 1'b1;
        else if (sentClr[i]) sent[i] <= 1'b0;

        if (stallClr[i]) stall[i] <= 1'b0;
        else if (stallSet[i]) stall[i] <= 1'b1;
        else if (setupC) stall[i] <= 1'b0;

        if (togClr[i]) inTog[i] <= 1'b0;
        else if (setupC) inTog[i] <= 1'b1;
        else if (hit && strb.inFlip) inTog[i] <= ~inTog[i];

        if (togClr[i]) outTog[i] <= 1'b0;
        else if (setupC) outTog[i] <= 1'b1;
        else if (hit && strb.outFlip) outTog[i] <= ~outTog[i];

        if (armC) begin
          inBufFlat[i*BufW +: BufW]    <= inSetBuf;
          inSizeFlat[i*SizeW +: SizeW] <= inSetSize;
        end
      end
    end
  end
endmodule

// File: rtl/usb_ep_handshake.sv
module usb_ep_handshake
  import usb_ep_pkg::*;
#(
  parameter int NumEps = 12,
  parameter int BufW   = 5,
  parameter int SizeW  = 7,
  parameter int MaxPkt = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tokValid,
  input  logic [1:0]        tokKind,
  input  logic [3:0]        tokEp,
  input  logic              dataValid,
  input  logic              dataGood,
  input  logic              dataPid,
  input  logic              hsValid,
  input  logic              hsAck,
  input  logic              linkReset,
  input  logic [NumEps-1:0] setupEn,
  input  logic [NumEps-1:0] outEn,
  input  logic [NumEps-1:0] isoEn,
  input  logic [NumEps-1:0] stallSet,
  input  logic [NumEps-1:0] stallClr,
  input  logic              inSetValid,
  input  logic [3:0]        inSetEp,
  input  logic [BufW-1:0]   inSetBuf,
  input  logic [SizeW-1:0]  inSetSize,
  input  logic [NumEps-1:0] sentClr,
  input  logic [NumEps-1:0] pendClr,
  input  logic [NumEps-1:0] togClr,
  output logic              rspValid,
  output logic [2:0]        rspKind,
  output logic [SizeW-1:0]  txBytes,
  output logic [BufW-1:0]   txBuf,
  output logic              txToggle,
  output logic [NumEps-1:0] inRdy,
  output logic [NumEps-1:0] stall,
  output logic [NumEps-1:0] sent,
  output logic [NumEps-1:0] pend,
  output logic [NumEps-1:0] inTog,
  output logic [NumEps-1:0] outTog,
  output logic              inErr,
  output logic              outErr,
  output logic              pktRx
);
  epStrobeT                strb;
  logic [NumEps*BufW-1:0]  inBufFlat;
  logic [NumEps*SizeW-1:0] inSizeFlat;

  usb_ep_ctrl #(
    .NumEps(NumEps), .BufW(BufW), .SizeW(SizeW), .MaxPkt(MaxPkt)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .tokValid(tokValid), .tokKind(tokKind), .tokEp(tokEp),
    .dataValid(dataValid), .dataGood(dataGood), .dataPid(dataPid),
    .hsValid(hsValid), .hsAck(hsAck), .linkReset(linkReset),
    .setupEn(setupEn), .outEn(outEn), .isoEn(isoEn),
    .stall(stall), .inRdy(inRdy), .outTog(outTog), .inTog(inTog),
    .inBufFlat(inBufFlat), .inSizeFlat(inSizeFlat),
    .strb(strb),
    .rspValid(rspValid), .rspKind(rspKind), .txBytes(txBytes),
    .txBuf(txBuf), .txToggle(txToggle),
    .inErr(inErr), .outErr(outErr), .pktRx(pktRx)
  );

  usb_ep_state #(
    .NumEps(NumEps), .BufW(BufW), .SizeW(SizeW)
  ) uState (
    .clk(clk), .rstN(rstN), .strb(strb), .linkReset(linkReset),
    .inSetValid(inSetValid), .inSetEp(inSetEp),
    .inSetBuf(inSetBuf), .inSetSize(inSetSize),
    .stallSet(stallSet), .stallClr(stallClr),
    .sentClr(sentClr), .pendClr(pendClr), .togClr(togClr),
    .inRdy(inRdy), .stall(stall), .sent(sent), .pend(pend),
    .inTog(inTog), .outTog(outTog),
    .inBufFlat(inBufFlat), .inSizeFlat(inSizeFlat)
  );
endmodule

// File: rtl/usb_ep_handshake_chk.sv
module usb_ep_handshake_chk #(
  parameter int NumEps = 12,
  parameter int SizeW  = 7,
  parameter int MaxPkt = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              tokValid,
  input logic              dataValid,
  input logic              dataGood,
  input logic              linkReset,
  input logic              inSetValid,
  input logic [NumEps-1:0] togClr,
  input logic              rspValid,
  input logic [2:0]        rspKind,
  input logic [SizeW-1:0]  txBytes,
  input logic [NumEps-1:0] inRdy,
  input logic [NumEps-1:0] sent,
  input logic [NumEps-1:0] pend,
  input logic [NumEps-1:0] inTog,
  input logic [NumEps-1:0] outTog,
  input logic              inErr,
  input logic              outErr,
  input logic              pktRx
);
  AST_DATA_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspKind == 3'd4) |-> (txBytes <= SizeW'(MaxPkt))); // R3

  AST_LINK_RESET_DISARMS: assert property (@(posedge clk) disable iff (!rstN)
    (linkReset && !inSetValid) |=> (inRdy == '0)); // R11

  AST_BAD_CRC_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !dataGood && !tokValid && !linkReset) |=> !rspValid); // R8

  AST_EVENT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({inErr, outErr, pktRx})); // R7

  for (genvar i = 0; i < NumEps; i++) begin : gChk
    AST_SENT_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rstN)
      $rose(sent[i]) |-> $past(inRdy[i])); // R4

    AST_PEND_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rstN)
      $rose(pend[i]) |-> $past(inRdy[i])); // R10

    AST_TOGGLE_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      togClr[i] |=> (!inTog[i] && !outTog[i])); // R13
  end
endmodule

bind usb_ep_handshake usb_ep_handshake_chk #(
  .NumEps(NumEps), .SizeW(SizeW), .MaxPkt(MaxPkt)
) uChk (
  .clk(clk), .rstN(rstN), .tokValid(tokValid), .dataValid(dataValid),
  .dataGood(dataGood), .linkReset(linkReset), .inSetValid(inSetValid),
  .togClr(togClr), .rspValid(rspValid), .rspKind(rspKind), .txBytes(txBytes),
  .inRdy(inRdy), .sent(sent), .pend(pend), .inTog(inTog), .outTog(outTog),
  .inErr(inErr), .outErr(outErr), .pktRx(pktRx)
);

// File: tb/tb_usb_ep_handshake.sv
`timescale 1ns/1ps
module tb_usb_ep_handshake;
  localparam int N = 12;

  logic clk = 1'b0, rstN = 1'b0;
  logic tokValid = 0, dataValid = 0, dataGood = 0, dataPid = 0;
  logic hsValid = 0, hsAck = 0, linkReset = 0, inSetValid = 0;
  logic [1:0] tokKind = 0;
  logic [3:0] tokEp = 0, inSetEp = 0;
  logic [N-1:0] setupEn = 0, outEn = 0, isoEn = 0, stallSet = 0, stallClr = 0;
  logic [N-1:0] sentClr = 0, pendClr = 0, togClr = 0;
  logic [4:0] inSetBuf = 0;
  logic [6:0] inSetSize = 0;
  logic rspValid, txToggle, inErr, outErr, pktRx;
  logic [2:0] rspKind;
  logic [6:0] txBytes;
  logic [4:0] txBuf;
  logic [N-1:0] inRdy, stall, sent, pend, inTog, outTog;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  usb_ep_handshake dut (.*);

  // ---------------- behavioural reference model ----------------
  logic [N-1:0] mRdy, mPend, mSent, mStall, mInT, mOutT;
  int mBuf[N], mSize[N];
  int mSt, mEp;
  bit mSetup;
  int eRspV, eRspK, eBytes, eBuf, eTog, eInErr, eOutErr, ePkt;

  always @(posedge clk) begin
    int e;
    if (!rstN) begin
      mRdy = 0; mPend = 0; mSent = 0; mStall = 0; mInT = 0; mOutT = 0;
      for (int i = 0; i < N; i++) begin mBuf[i] = 0; mSize[i] = 0; end
      mSt = 0; mEp = 0; mSetup = 0;
      eRspV = 0; eRspK = 0; eBytes = 0; eBuf = 0; eTog = 0;
      eInErr = 0; eOutErr = 0; ePkt = 0;
    end else begin
      eRspV = 0; eRspK = 0; eInErr = 0; eOutErr = 0; ePkt = 0;
      mSent = mSent & ~sentClr;
      mPend = mPend & ~pendClr;
      if (linkReset) begin
        mSt = 0; mPend = mPend | mRdy; mRdy = 0;
      end else if (tokValid) begin
        if (mSt == 2) eInErr = 1;
        mSt = 0;
        if (tokEp < N) begin
          e = int'(tokEp);
          if (tokKind == 2'd1) begin
            eRspV = 1;
            if (mStall[e]) eRspK = 3;
            else if (!mRdy[e]) eRspK = 2;
            else begin
              eRspK = 4;
              eBytes = (mSize[e] > 64) ? 64 : mSize[e];
              eBuf = mBuf[e]; eTog = int'(mInT[e]);
              if (isoEn[e]) begin mRdy[e] = 0; mSent[e] = 1; end
              else begin mSt = 2; mEp = e; end
            end
          end else if (tokKind == 2'd0 || tokKind == 2'd2) begin
            mSt = 1; mEp = e; mSetup = (tokKind == 2'd2);
          end
        end
      end else if (dataValid && mSt == 1) begin
        mSt = 0; e = mEp;
        if (!dataGood) eOutErr = 1;
        else if (mSetup) begin
          eRspV = 1;
          if (!setupEn[e]) eRspK = 2;
          else begin
            eRspK = 1; ePkt = 1; mStall[e] = 0; mInT[e] = 1; mOutT[e] = 1;
            if (mRdy[e]) begin mPend[e] = 1; mRdy[e] = 0; end
          end
        end else if (mStall[e]) begin eRspV = 1; eRspK = 3; end
        else if (!outEn[e]) begin eRspV = 1; eRspK = 2; end
        else if (isoEn[e]) ePkt = 1;
        else begin
          eRspV = 1; eRspK = 1;
          if (dataPid != mOutT[e]) eOutErr = 1;
          else begin ePkt = 1; mOutT[e] = ~mOutT[e]; end
        end
      end else if (hsValid && mSt == 2) begin
        mSt = 0;
        if (hsAck) begin mRdy[mEp] = 0; mSent[mEp] = 1; mInT[mEp] = ~mInT[mEp]; end
        else eInErr = 1;
      end
      mStall = (mStall | stallSet) & ~stallClr;
      mInT = mInT & ~togClr;
      mOutT = mOutT & ~togClr;
      if (inSetValid && inSetEp < N) begin
        mRdy[inSetEp] = 1; mBuf[inSetEp] = int'(inSetBuf); mSize[inSetEp] = int'(inSetSize);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2 rspValid", int'(rspValid), eRspV);
      chk("R2 rspKind", int'(rspKind), eRspK);
      if (eRspK == 4) begin
        chk("R3 txBytes", int'(txBytes), eBytes);
        chk("R2 txBuf", int'(txBuf), eBuf);
        chk("R2 txToggle", int'(txToggle), eTog);
      end
      chk("R4 inRdy", int'(inRdy), int'(mRdy));
      chk("R4 sent", int'(sent), int'(mSent));
      chk("R10 pend", int'(pend), int'(mPend));
      chk("R9 stall", int'(stall), int'(mStall));
      chk("R13 inTog", int'(inTog), int'(mInT));
      chk("R13 outTog", int'(outTog), int'(mOutT));
      chk("R5 inErr", int'(inErr), eInErr);
      chk("R7 outErr", int'(outErr), eOutErr);
      chk("R6 pktRx", int'(pktRx), ePkt);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic tokT(input int k, input int ep);
    tokValid = 1; tokKind = 2'(k); tokEp = 4'(ep);
    @(negedge clk); tokValid = 0;
  endtask
  task automatic dataT(input bit good, input bit pid);
    dataValid = 1; dataGood = good; dataPid = pid;
    @(negedge clk); dataValid = 0;
  endtask
  task automatic hsT(input bit ack);
    hsValid = 1; hsAck = ack;
    @(negedge clk); hsValid = 0;
  endtask
  task automatic armT(input int ep, input int b, input int sz);
    inSetValid = 1; inSetEp = 4'(ep); inSetBuf = 5'(b); inSetSize = 7'(sz);
    @(negedge clk); inSetValid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rspValid", int'(rspValid), 0);
    chk("R1 flags", int'(inRdy | stall | sent | pend | inTog | outTog), 0);
    setupEn = 12'h00F; outEn = 12'h00F; isoEn = 12'h008;

    tokT(1, 1);                       // R2 unarmed IN
    chk("R2 nack unarmed", int'(rspKind), 2);
    armT(1, 5, 10);
    tokT(1, 1);
    chk("R2 data kind", int'(rspKind), 4);
    chk("R2 data buf", int'(txBuf), 5);
    chk("R3 size kept", int'(txBytes), 10);
    chk("R2 data toggle", int'(txToggle), 0);
    hsT(1);                            // R4
    chk("R4 disarmed", int'(inRdy[1]), 0);
    chk("R4 sent set", int'(sent[1]), 1);
    chk("R4 toggle flip", int'(inTog[1]), 1);
    sentClr = 12'h002; @(negedge clk); sentClr = 0;
    chk("R4 sent cleared", int'(sent[1]), 0);

    armT(1, 7, 100);
    tokT(1, 1);
    chk("R3 clamp", int'(txBytes), 64);
    hsT(0);                            // R5
    chk("R5 nak handshake", int'(inErr), 1);
    chk("R5 still armed", int'(inRdy[1]), 1);
    tokT(1, 1);
    tokT(0, 2);
    chk("R5 token interrupts", int'(inErr), 1);
    dataT(1, 0);                       // R6
    chk("R6 ack", int'(rspKind), 1);
    chk("R6 pktRx", int'(pktRx), 1);
    chk("R6 outTog", int'(outTog[2]), 1);
    tokT(0, 2); dataT(1, 0);           // R7
    chk("R7 ack", int'(rspKind), 1);
    chk("R7 outErr", int'(outErr), 1);
    chk("R7 no pkt", int'(pktRx), 0);
    chk("R7 tog held", int'(outTog[2]), 1);
    tokT(0, 2); dataT(0, 1);           // R8
    chk("R8 silent", int'(rspValid), 0);
    chk("R8 outErr", int'(outErr), 1);

    armT(1, 7, 0);
    tokT(1, 1);
    chk("R3 zero length", int'(txBytes), 0);
    hsT(1);

    tokT(0, 5); dataT(1, 0);
    chk("R6 disabled nack", int'(rspKind), 2);
    stallSet = 12'h004; @(negedge clk); stallSet = 0;
    tokT(0, 2); dataT(1, 1);
    chk("R6 out stall", int'(rspKind), 3);
    tokT(1, 2);
    chk("R2 in stall", int'(rspKind), 3);

    armT(2, 3, 8);
    tokT(2, 2); dataT(1, 0);           // R9 R10
    chk("R9 setup ack", int'(rspKind), 1);
    chk("R9 pkt", int'(pktRx), 1);
    chk("R9 stall cleared", int'(stall[2]), 0);
    chk("R9 toggles", int'({inTog[2], outTog[2]}), 3);
    chk("R10 disarmed", int'(inRdy[2]), 0);
    chk("R10 pend", int'(pend[2]), 1);
    pendClr = 12'h004; @(negedge clk); pendClr = 0;
    chk("R10 pend cleared", int'(pend[2]), 0);
    tokT(2, 6); dataT(1, 0);
    chk("R9 disabled nack", int'(rspKind), 2);

    tokT(0, 3); dataT(1, 0);           // R12
    chk("R12 no handshake", int'(rspValid), 0);
    chk("R12 pkt", int'(pktRx), 1);
    armT(3, 1, 4);
    tokT(1, 3);
    chk("R12 data", int'(rspKind), 4);
    chk("R12 done at once", int'({inRdy[3], sent[3]}), 1);

    togClr = 12'h004; @(negedge clk); togClr = 0;
    chk("R13 toggles clear", int'({inTog[2], outTog[2]}), 0);

    armT(0, 0, 2); armT(1, 1, 2);      // R11
    tokT(1, 0);
    linkReset = 1; @(negedge clk); linkReset = 0;
    chk("R11 all disarmed", int'(inRdy), 0);
    chk("R11 pend", int'(pend[1:0]), 3);
    hsT(1);
    chk("R11 handshake dropped", int'(sent[0]), 0);

    // pseudo-random overlap phase, compared with the model every clock
    for (int c = 0; c < 3000; c++) begin
      tokValid   = ($urandom % 5) == 0;
      tokKind    = 2'($urandom % 4);
      tokEp      = 4'($urandom % 16);
      dataValid  = ($urandom % 3) == 0;
      dataGood   = ($urandom % 5) != 0;
      dataPid    = 1'($urandom % 2);
      hsValid    = ($urandom % 3) == 0;
      hsAck      = ($urandom % 4) != 0;
      linkReset  = ($urandom % 60) == 0;
      inSetValid = ($urandom % 4) == 0;
      inSetEp    = 4'($urandom % 16);
      inSetBuf   = 5'($urandom);
      inSetSize  = 7'($urandom);
      stallSet   = (($urandom % 8) == 0) ? N'($urandom) : '0;
      stallClr   = (($urandom % 8) == 0) ? N'($urandom) : '0;
      sentClr    = (($urandom % 4) == 0) ? N'($urandom) : '0;
      pendClr    = (($urandom % 4) == 0) ? N'($urandom) : '0;
      togClr     = (($urandom % 10) == 0) ? N'($urandom) : '0;
      if (($urandom % 50) == 0) begin
        setupEn = N'($urandom); outEn = N'($urandom); isoEn = N'($urandom);
      end
      @(negedge clk);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule